// File: doc/BRIEF.md
# Software-Refilled Associative Translation Buffer

This block holds a small set of page translations and answers lookups against all of them at once. A lookup presents a virtual page number plus an access kind (load or store). One clock later the block reports whether a valid entry tagged with the current address space identifier matched, which physical frame it gives, and whether an exception arises. An exception arises either because nothing matched or because a store touched a page marked read-only. The block never walks a page table. Refill is left entirely to software, which installs translations through a management port.

The management port takes one command per cycle. A write command installs the given fields at a chosen slot. A read command returns every field of a chosen slot. A probe command searches for a page number and identifier pair and returns the slot it sits in. A separate flush input drops every translation in a single cycle, for use when identifiers are recycled. The current identifier lives in a register that software loads through its own strobe.

Top module: `tlb_soft`

## Requirements
- R1: Synchronous active-high reset clears every valid flag, sets the current identifier to 0 and drives every output to 0; a lookup right after reset reports a miss.
- R2: A lookup matches an entry only when that entry is valid, its page number equals the looked-up page number, and its identifier equals the current identifier register (loaded from `asid_in` when `asid_set` is 1).
- R3: A lookup presented with `lk_req` high in the cycle before clock edge N has `lk_done` high after edge N, with `lk_hit` set and `lk_pfn` holding the matched entry's frame number on a hit.
- R4: When no entry matches, the lookup result has `lk_miss_exc` 1, `lk_hit` 0 and `lk_pfn` 0; hit and miss are never reported together.
- R5: A store lookup (`lk_store` 1) that hits an entry whose read-only flag is 1 reports `lk_ro_exc` 1 alongside `lk_hit` 1; a load to that entry, or a store to a writable entry, reports `lk_ro_exc` 0.
- R6: A write command (`mg_cmd` = 2'b01) stores page number, frame number, identifier, valid and read-only flag at slot `mg_idx` on the next clock edge; a lookup in the same cycle as the write sees the slot's previous contents.
- R7: A read command (`mg_cmd` = 2'b10) returns all five fields of slot `mg_idx` on the `mg_rd_*` outputs one cycle later; every non-idle command (2'b01, 2'b10, 2'b11) pulses `mg_done` one cycle later, and 2'b00 is idle.
- R8: A probe command (`mg_cmd` = 2'b11) searches valid entries for `mg_vpn` with identifier `mg_asid`, and one cycle later reports `mg_found` 1 with the lowest matching slot in `mg_probe_idx`, or `mg_found` 0 with `mg_probe_idx` 0.
- R9: When several valid entries match a lookup, the frame number of the lowest-numbered matching slot is returned.
- R10: `inval_all` clears the valid flag of every slot on the next edge; a write command in the same cycle still stores its fields but leaves that slot invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| asid_set | input | 1 | Load the current identifier register |
| asid_in | input | 6 | New current identifier |
| inval_all | input | 1 | Clear every valid flag |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Page number to translate |
| lk_store | input | 1 | Access is a store |
| lk_done | output | 1 | Lookup result present |
| lk_hit | output | 1 | A valid entry matched |
| lk_pfn | output | 20 | Frame number of the match, 0 on miss |
| lk_miss_exc | output | 1 | Miss exception |
| lk_ro_exc | output | 1 | Read-only violation exception |
| mg_cmd | input | 2 | 00 idle, 01 write, 10 read, 11 probe |
| mg_idx | input | 6 | Slot for write and read |
| mg_vpn | input | 20 | Page number for write and probe |
| mg_pfn | input | 20 | Frame number for write |
| mg_asid | input | 6 | Identifier for write and probe |
| mg_valid | input | 1 | Valid flag for write |
| mg_ro | input | 1 | Read-only flag for write |
| mg_done | output | 1 | Management command completed |
| mg_rd_vpn | output | 20 | Page number read back |
| mg_rd_pfn | output | 20 | Frame number read back |
| mg_rd_asid | output | 6 | Identifier read back |
| mg_rd_valid | output | 1 | Valid flag read back |
| mg_rd_ro | output | 1 | Read-only flag read back |
| mg_found | output | 1 | Probe found a match |
| mg_probe_idx | output | 6 | Lowest matching slot of the probe |

## Verification
A lookup and a management write can land in the same cycle, and so can a flush and a write. The vector table provokes the first case by installing an entry and looking up its page number in the very cycle of the write, then repeating the lookup alone; the first result must be a miss (or the old frame number when an earlier duplicate exists) and the second a hit with the new frame. The second case is provoked by issuing a valid write together with the flush and reading the slot back, which must show its fields with the valid flag cleared.

// File: rtl/tlb_soft_pkg.sv
package tlb_soft_pkg;

  typedef enum logic [1:0] {
    MG_IDLE  = 2'b00,
    MG_WRITE = 2'b01,
    MG_READ  = 2'b10,
    MG_PROBE = 2'b11
  } mg_cmd_e;

endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int N      = 64,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 6,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         flush,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [VPN_W-1:0]             wr_vpn,
  input  logic [PFN_W-1:0]             wr_pfn,
  input  logic [ASID_W-1:0]            wr_asid,
  input  logic                         wr_valid,
  input  logic                         wr_ro,
  output logic [N-1:0]                 valid_q,
  output logic [N-1:0]                 ro_q,
  output logic [N-1:0][VPN_W-1:0]      vpn_q,
  output logic [N-1:0][PFN_W-1:0]      pfn_q,
  output logic [N-1:0][ASID_W-1:0]     asid_q
);

  // Payload fields carry no reset so they map onto plain distributed storage.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_idx]  <= wr_vpn;
      pfn_q[wr_idx]  <= wr_pfn;
      asid_q[wr_idx] <= wr_asid;
      ro_q[wr_idx]   <= wr_ro;
    end
  end

  // Valid flags: reset and flush dominate any write.
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= wr_valid;
    end
  end

endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N      = 64,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 6
) (
  input  logic [N-1:0]             valid_q,
  input  logic [N-1:0][VPN_W-1:0]  vpn_q,
  input  logic [N-1:0][ASID_W-1:0] asid_q,
  input  logic [VPN_W-1:0]         key_vpn,
  input  logic [ASID_W-1:0]        key_asid,
  output logic [N-1:0]             match
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (vpn_q[g] == key_vpn) && (asid_q[g] == key_asid);
  end

endmodule

// File: rtl/tlb_prio.sv
module tlb_prio #(
  parameter int N      = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/tlb_soft.sv
module tlb_soft
  import tlb_soft_pkg::*;
#(
  parameter int N      = 64,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 6,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              asid_set,
  input  logic [ASID_W-1:0] asid_in,
  input  logic              inval_all,
  input  logic              lk_req,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic              lk_store,
  output logic              lk_done,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic              lk_miss_exc,
  output logic              lk_ro_exc,
  input  logic [1:0]        mg_cmd,
  input  logic [IDX_W-1:0]  mg_idx,
  input  logic [VPN_W-1:0]  mg_vpn,
  input  logic [PFN_W-1:0]  mg_pfn,
  input  logic [ASID_W-1:0] mg_asid,
  input  logic              mg_valid,
  input  logic              mg_ro,
  output logic              mg_done,
  output logic [VPN_W-1:0]  mg_rd_vpn,
  output logic [PFN_W-1:0]  mg_rd_pfn,
  output logic [ASID_W-1:0] mg_rd_asid,
  output logic              mg_rd_valid,
  output logic              mg_rd_ro,
  output logic              mg_found,
  output logic [IDX_W-1:0]  mg_probe_idx
);

  mg_cmd_e cmd;
  assign cmd = mg_cmd_e'(mg_cmd);

  logic [ASID_W-1:0] cur_asid;

  logic [N-1:0]               valid_q, ro_q;
  logic [N-1:0][VPN_W-1:0]    vpn_q;
  logic [N-1:0][PFN_W-1:0]    pfn_q;
  logic [N-1:0][ASID_W-1:0]   asid_q;

  logic [N-1:0]     lk_match, pr_match;
  logic             lk_any, pr_any;
  logic [IDX_W-1:0] lk_idx, pr_idx;

  always_ff @(posedge clk) begin
    if (rst)           cur_asid <= '0;
    else if (asid_set) cur_asid <= asid_in;
  end

  tlb_store #(.N(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cmd == MG_WRITE),
    .flush    (inval_all),
    .wr_idx   (mg_idx),
    .wr_vpn   (mg_vpn),
    .wr_pfn   (mg_pfn),
    .wr_asid  (mg_asid),
    .wr_valid (mg_valid),
    .wr_ro    (mg_ro),
    .valid_q  (valid_q),
    .ro_q     (ro_q),
    .vpn_q    (vpn_q),
    .pfn_q    (pfn_q),
    .asid_q   (asid_q)
  );

  tlb_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam_lk (
    .valid_q  (valid_q),
    .vpn_q    (vpn_q),
    .asid_q   (asid_q),
    .key_vpn  (lk_vpn),
    .key_asid (cur_asid),
    .match    (lk_match)
  );

  tlb_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam_pr (
    .valid_q  (valid_q),
    .vpn_q    (vpn_q),
    .asid_q   (asid_q),
    .key_vpn  (mg_vpn),
    .key_asid (mg_asid),
    .match    (pr_match)
  );

  tlb_prio #(.N(N)) u_prio_lk (.req(lk_match), .any(lk_any), .idx(lk_idx));
  tlb_prio #(.N(N)) u_prio_pr (.req(pr_match), .any(pr_any), .idx(pr_idx));

  // Translation result, registered.
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_done     <= 1'b0;
      lk_hit      <= 1'b0;
      lk_pfn      <= '0;
      lk_miss_exc <= 1'b0;
      lk_ro_exc   <= 1'b0;
    end else begin
      lk_done     <= lk_req;
      lk_hit      <= lk_req && lk_any;
      lk_pfn      <= (lk_req && lk_any) ? pfn_q[lk_idx] : '0;
      lk_miss_exc <= lk_req && !lk_any;
      lk_ro_exc   <= lk_req && lk_any && lk_store && ro_q[lk_idx];
    end
  end

  // Management result, registered.
  always_ff @(posedge clk) begin
    if (rst) begin
      mg_done      <= 1'b0;
      mg_rd_vpn    <= '0;
      mg_rd_pfn    <= '0;
      mg_rd_asid   <= '0;
      mg_rd_valid  <= 1'b0;
      mg_rd_ro     <= 1'b0;
      mg_found     <= 1'b0;
      mg_probe_idx <= '0;
    end else begin
      mg_done <= (cmd != MG_IDLE);
      if (cmd == MG_READ) begin
        mg_rd_vpn   <= vpn_q[mg_idx];
        mg_rd_pfn   <= pfn_q[mg_idx];
        mg_rd_asid  <= asid_q[mg_idx];
        mg_rd_valid <= valid_q[mg_idx];
        mg_rd_ro    <= ro_q[mg_idx];
      end
      if (cmd == MG_PROBE) begin
        mg_found     <= pr_any;
        mg_probe_idx <= pr_any ? pr_idx : '0;
      end
    end
  end

endmodule

// File: rtl/tlb_soft_chk.sv
module tlb_soft_chk #(
  parameter int PFN_W = 20,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             inval_all,
  input logic             lk_req,
  input logic             lk_store,
  input logic             lk_done,
  input logic             lk_hit,
  input logic [PFN_W-1:0] lk_pfn,
  input logic             lk_miss_exc,
  input logic             lk_ro_exc,
  input logic [1:0]       mg_cmd,
  input logic             mg_done,
  input logic             mg_found,
  input logic [IDX_W-1:0] mg_probe_idx
);

  // R3
  lk_done_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> lk_done);

  // R4
  hit_miss_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    lk_done |-> (lk_hit != lk_miss_exc));

  // R4
  pfn_zero_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_pfn == '0));

  // R5
  ro_exc_needs_store_hit_chk: assert property (@(posedge clk) disable iff (rst)
    lk_ro_exc |-> (lk_hit && $past(lk_store)));

  // R10
  flush_then_miss_chk: assert property (@(posedge clk) disable iff (rst)
    inval_all ##1 lk_req |=> lk_miss_exc);

  // R7
  mg_done_follows_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (mg_cmd != 2'b00) |=> mg_done);

  // R8
  probe_idx_zero_when_absent_chk: assert property (@(posedge clk) disable iff (rst)
    !mg_found |-> (mg_probe_idx == '0));

endmodule

bind tlb_soft tlb_soft_chk #(.PFN_W(PFN_W), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .inval_all    (inval_all),
  .lk_req       (lk_req),
  .lk_store     (lk_store),
  .lk_done      (lk_done),
  .lk_hit       (lk_hit),
  .lk_pfn       (lk_pfn),
  .lk_miss_exc  (lk_miss_exc),
  .lk_ro_exc    (lk_ro_exc),
  .mg_cmd       (mg_cmd),
  .mg_done      (mg_done),
  .mg_found     (mg_found),
  .mg_probe_idx (mg_probe_idx)
);

// File: tb/tlb_soft_test.sv
module tlb_soft_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        asid_set;
  logic [5:0]  asid_in;
  logic        inval_all;
  logic        lk_req;
  logic [19:0] lk_vpn;
  logic        lk_store;
  logic        lk_done, lk_hit, lk_miss_exc, lk_ro_exc;
  logic [19:0] lk_pfn;
  logic [1:0]  mg_cmd;
  logic [5:0]  mg_idx;
  logic [19:0] mg_vpn, mg_pfn;
  logic [5:0]  mg_asid;
  logic        mg_valid, mg_ro;
  logic        mg_done, mg_rd_valid, mg_rd_ro, mg_found;
  logic [19:0] mg_rd_vpn, mg_rd_pfn;
  logic [5:0]  mg_rd_asid, mg_probe_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  tlb_soft uut (
    .clk(clk), .rst(rst), .asid_set(asid_set), .asid_in(asid_in), .inval_all(inval_all),
    .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_store(lk_store), .lk_done(lk_done),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_miss_exc(lk_miss_exc), .lk_ro_exc(lk_ro_exc),
    .mg_cmd(mg_cmd), .mg_idx(mg_idx), .mg_vpn(mg_vpn), .mg_pfn(mg_pfn), .mg_asid(mg_asid),
    .mg_valid(mg_valid), .mg_ro(mg_ro), .mg_done(mg_done), .mg_rd_vpn(mg_rd_vpn),
    .mg_rd_pfn(mg_rd_pfn), .mg_rd_asid(mg_rd_asid), .mg_rd_valid(mg_rd_valid),
    .mg_rd_ro(mg_rd_ro), .mg_found(mg_found), .mg_probe_idx(mg_probe_idx)
  );

  typedef struct packed {
    logic [1:0]  cmd;
    logic [5:0]  idx;
    logic [19:0] vpn;
    logic [19:0] pfn;
    logic [5:0]  asid;
    logic        v;
    logic        ro;
    logic        lk;
    logic [19:0] lvpn;
    logic        st;
    logic        e_hit;
    logic [19:0] e_pfn;
    logic        e_miss;
    logic        e_ro;
  } vec_t;

  localparam int NV = 13;
  // Current identifier is 0 throughout the table.
  localparam vec_t VEC [NV] = '{
    '{2'b01, 6'd5,  20'h00400, 20'h00200, 6'd0, 1'b1, 1'b0, 1'b1, 20'h00400, 1'b0, 1'b0, 20'h0,     1'b1, 1'b0}, // R6 old contents
    '{2'b00, 6'd0,  20'h0,     20'h0,     6'd0, 1'b0, 1'b0, 1'b1, 20'h00400, 1'b0, 1'b1, 20'h00200, 1'b0, 1'b0}, // R3 hit
    '{2'b01, 6'd9,  20'h10000, 20'h00800, 6'd0, 1'b1, 1'b1, 1'b1, 20'h10000, 1'b1, 1'b0, 20'h0,     1'b1, 1'b0}, // R6
    '{2'b00, 6'd0,  20'h0,     20'h0,     6'd0, 1'b0, 1'b0, 1'b1, 20'h10000, 1'b1, 1'b1, 20'h00800, 1'b0, 1'b1}, // R5 store to ro
    '{2'b00, 6'd0,  20'h0,     20'h0,     6'd0, 1'b0, 1'b0, 1'b1, 20'h10000, 1'b0, 1'b1, 20'h00800, 1'b0, 1'b0}, // R5 load to ro
    '{2'b01, 6'd12, 20'h7FFF4, 20'h00B00, 6'd3, 1'b1, 1'b0, 1'b1, 20'h7FFF4, 1'b0, 1'b0, 20'h0,     1'b1, 1'b0}, // R6
    '{2'b00, 6'd0,  20'h0,     20'h0,     6'd0, 1'b0, 1'b0, 1'b1, 20'h7FFF4, 1'b0, 1'b0, 20'h0,     1'b1, 1'b0}, // R2 ident mismatch
    '{2'b01, 6'd20, 20'h12345, 20'h0ABCD, 6'd0, 1'b0, 1'b0, 1'b1, 20'h0ABCD, 1'b0, 1'b0, 20'h0,     1'b1, 1'b0}, // R4
    '{2'b00, 6'd0,  20'h0,     20'h0,     6'd0, 1'b0, 1'b0, 1'b1, 20'h12345, 1'b0, 1'b0, 20'h0,     1'b1, 1'b0}, // R2 invalid entry
    '{2'b01, 6'd40, 20'h00400, 20'h0FFFF, 6'd0, 1'b1, 1'b0, 1'b1, 20'h00400, 1'b0, 1'b1, 20'h00200, 1'b0, 1'b0}, // R9 higher dup
    '{2'b01, 6'd2,  20'h00400, 20'h0CAFE, 6'd0, 1'b1, 1'b0, 1'b1, 20'h00400, 1'b0, 1'b1, 20'h00200, 1'b0, 1'b0}, // R6 old
    '{2'b00, 6'd0,  20'h0,     20'h0,     6'd0, 1'b0, 1'b0, 1'b1, 20'h00400, 1'b0, 1'b1, 20'h0CAFE, 1'b0, 1'b0}, // R9 lowest
    '{2'b00, 6'd0,  20'h0,     20'h0,     6'd0, 1'b0, 1'b0, 1'b1, 20'h00400, 1'b1, 1'b1, 20'h0CAFE, 1'b0, 1'b0}  // R5 store writable
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    asid_set = 0; asid_in = 0; inval_all = 0;
    lk_req = 0; lk_vpn = 0; lk_store = 0;
    mg_cmd = 2'b00; mg_idx = 0; mg_vpn = 0; mg_pfn = 0; mg_asid = 0; mg_valid = 0; mg_ro = 0;
  endtask

  // Drive at a falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic lookup(input logic [19:0] v, input logic st);
    lk_req = 1; lk_vpn = v; lk_store = st;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic mgmt(input logic [1:0] c, input logic [5:0] i, input logic [19:0] v,
                      input logic [19:0] p, input logic [5:0] a, input logic vl, input logic r);
    mg_cmd = c; mg_idx = i; mg_vpn = v; mg_pfn = p; mg_asid = a; mg_valid = vl; mg_ro = r;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle_inputs();
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    // R1: outputs cleared by reset
    chk("R1 reset outputs", {lk_done, lk_hit, lk_pfn, lk_miss_exc, lk_ro_exc, mg_done, mg_found, mg_probe_idx},
        64'h0);
    lookup(20'h00000, 1'b0);
    chk("R1 lookup after reset misses", {lk_done, lk_hit, lk_miss_exc}, {1'b1, 1'b0, 1'b1});

    for (int k = 0; k < NV; k++) begin
      mg_cmd = VEC[k].cmd; mg_idx = VEC[k].idx; mg_vpn = VEC[k].vpn; mg_pfn = VEC[k].pfn;
      mg_asid = VEC[k].asid; mg_valid = VEC[k].v; mg_ro = VEC[k].ro;
      lk_req = VEC[k].lk; lk_vpn = VEC[k].lvpn; lk_store = VEC[k].st;
      @(negedge clk);
      idle_inputs();
      chk($sformatf("vector %0d R2 R3 R4 R5 R6 R9", k),
          {lk_done, lk_hit, lk_pfn, lk_miss_exc, lk_ro_exc},
          {1'b1, VEC[k].e_hit, VEC[k].e_pfn, VEC[k].e_miss, VEC[k].e_ro});
    end

    // R2: switching the current identifier makes the tagged entry visible
    asid_set = 1; asid_in = 6'd3;
    @(negedge clk);
    idle_inputs();
    lookup(20'h7FFF4, 1'b0);
    chk("R2 ident 3 hit", {lk_hit, lk_pfn, lk_miss_exc}, {1'b1, 20'h00B00, 1'b0});
    lookup(20'h00400, 1'b0);
    chk("R2 ident 3 hides ident 0", {lk_hit, lk_miss_exc}, {1'b0, 1'b1});
    asid_set = 1; asid_in = 6'd0;
    @(negedge clk);
    idle_inputs();

    // R7: read back
    mgmt(2'b10, 6'd9, 20'h0, 20'h0, 6'd0, 1'b0, 1'b0);
    chk("R7 read slot 9", {mg_done, mg_rd_vpn, mg_rd_pfn, mg_rd_asid, mg_rd_valid, mg_rd_ro},
        {1'b1, 20'h10000, 20'h00800, 6'd0, 1'b1, 1'b1});
    mgmt(2'b10, 6'd20, 20'h0, 20'h0, 6'd0, 1'b0, 1'b0);
    chk("R7 read invalid slot 20", {mg_rd_vpn, mg_rd_pfn, mg_rd_valid}, {20'h12345, 20'h0ABCD, 1'b0});
    @(negedge clk);
    chk("R7 idle gives no done", {63'h0, mg_done}, 64'h0);

    // R8: probe
    mgmt(2'b11, 6'd0, 20'h00400, 20'h0, 6'd0, 1'b0, 1'b0);
    chk("R8 probe lowest of three", {mg_done, mg_found, mg_probe_idx}, {1'b1, 1'b1, 6'd2});
    mgmt(2'b11, 6'd0, 20'h12345, 20'h0, 6'd0, 1'b0, 1'b0);
    chk("R8 probe invalid entry", {mg_found, mg_probe_idx}, {1'b0, 6'd0});
    mgmt(2'b11, 6'd0, 20'h7FFF4, 20'h0, 6'd3, 1'b0, 1'b0);
    chk("R8 probe other ident", {mg_found, mg_probe_idx}, {1'b1, 6'd12});
    mgmt(2'b11, 6'd0, 20'h7FFF4, 20'h0, 6'd0, 1'b0, 1'b0);
    chk("R8 probe wrong ident", {mg_found, mg_probe_idx}, {1'b0, 6'd0});

    // R10: flush together with a valid write
    inval_all = 1;
    mgmt(2'b01, 6'd7, 20'h55555, 20'h0AAAA, 6'd0, 1'b1, 1'b0);
    mgmt(2'b10, 6'd7, 20'h0, 20'h0, 6'd0, 1'b0, 1'b0);
    chk("R10 write under flush", {mg_rd_vpn, mg_rd_pfn, mg_rd_valid}, {20'h55555, 20'h0AAAA, 1'b0});
    mgmt(2'b10, 6'd2, 20'h0, 20'h0, 6'd0, 1'b0, 1'b0);
    chk("R10 slot 2 flushed", {63'h0, mg_rd_valid}, 64'h0);
    lookup(20'h00400, 1'b0);
    chk("R10 lookup after flush", {lk_hit, lk_miss_exc}, {1'b0, 1'b1});

    // R1: reset in mid-run drops a fresh entry
    mgmt(2'b01, 6'd1, 20'h00777, 20'h00123, 6'd0, 1'b1, 1'b0);
    lookup(20'h00777, 1'b0);
    chk("R1 entry live before reset", {lk_hit, lk_pfn}, {1'b1, 20'h00123});
    rst = 1;
    @(negedge clk);
    rst = 0;
    lookup(20'h00777, 1'b0);
    chk("R1 entry gone after reset", {lk_hit, lk_miss_exc}, {1'b0, 1'b1});

    finish_run();
  end

endmodule